// File: doc/BRIEF.md
# BMC-Side Shared-Window Packet Channel Controller

This block sits on the management-controller side of a host link. Packets travel through a shared memory window, and a one-byte mailbox register pair carries the notifications. The controller publishes the control area in the window when it comes out of reset and raises a "controller up" status bit. It then answers the host's commands. When the host asks to initialise, the controller negotiates the channel and raises a "channel up" bit. When the host hands over a packet, the controller passes it to local logic as a start address and a length, and returns ownership once the local logic acknowledges. Local logic can send packets in the other direction through a request/ready handshake, and buffer ownership is tracked for that direction as well.

A write to the status register cannot be relied on to interrupt the host. For that reason every status change is followed by a dummy byte (0xFF) in the output data register. Bytes bound for the output data register wait in a small FIFO and go out only while the host-side Output Buffer Full flag is clear. Command byte codes are: 0x00 initialise, 0x01 packet handed over (transmit begin), 0x02 packet consumed (receive complete), 0xFF dummy.

The memory port is word-oriented with byte addresses. The data of each word is the 32-bit big-endian value of the field.

Top module: `pktchan_ctrl`

## Requirements
- R1: After reset the controller writes six control words on consecutive cycles, in this order: 0x00 = 0x4D435450, 0x04 = {VER_MIN,VER_CUR}, 0x10 = TXA_OFF, 0x14 = AREA_BYTES, 0x18 = RXA_OFF, 0x1C = AREA_BYTES. Only after these does it write status 0x80. While reset is held, every strobe output and `tx_ready` are low.
- R2: Each status write (bit 7 controller up, bit 6 channel up, bits 5..0 zero) enqueues the dummy byte 0xFF. With the queue empty and Output Buffer Full clear, the dummy goes out on the output data register in the cycle after the status write.
- R3: The output data register is never written while `mb_obf` is high, nor in the cycle right after a previous write. Queued bytes leave in the order they were queued. A byte queued behind a byte the host holds goes out two cycles after the host releases Output Buffer Full.
- R4: On command 0x00 the controller pulses `mb_idr_rd` and writes word 0x0C = {NEG_VER,16'h0}. On the next cycle it writes status 0xC0, and the dummy follows.
- R5: A 0x00 received while the channel is up first writes status 0x80, then performs R4. It also drops any pending receive handoff and frees the transmit area.
- R6: A 0x01 received while the channel is up reads the word at RXA_OFF. `rx_valid` rises three cycles after the command is taken, with `rx_addr` = RXA_OFF+4.
- R7: While `rx_valid` is high, `rx_ack` makes `rx_valid` fall on the next cycle and queues 0x02 for the host.
- R8: When `tx_ready` and `tx_req` are both high, the controller writes `tx_len` to TXA_OFF and queues 0x01. `tx_ready` stays low until the host sends 0x02. `tx_addr` equals TXA_OFF+4.
- R9: A 0x01 or 0x02 received before the channel is up, or any code other than 0x00/0x01/0x02, is dropped with a one-cycle `err` pulse. It causes no memory access and no output data byte.
- R10: While the channel is up, memory writes go only to TXA_OFF. The control area and the receive area are never written.
- R11: A received length word larger than AREA_BYTES-4 is presented as AREA_BYTES-4. Smaller values pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mb_ibf | input | 1 | Host has written the input data register |
| mb_idr | input | 8 | Input data register contents |
| mb_idr_rd | output | 1 | Read strobe for the input data register; clears `mb_ibf` |
| mb_obf | input | 1 | Output data register not yet read by the host |
| mb_odr_wr | output | 1 | Output data register write strobe |
| mb_odr_data | output | 8 | Byte written to the output data register |
| mb_str_wr | output | 1 | Status register write strobe |
| mb_str_data | output | 8 | Status value |
| mem_we | output | 1 | Window write strobe |
| mem_re | output | 1 | Window read strobe; data returned the next cycle |
| mem_addr | output | AW | Window byte address |
| mem_wdata | output | 32 | Window write data |
| mem_rdata | input | 32 | Window read data |
| tx_req | input | 1 | Local logic requests a send |
| tx_len | input | LW | Length of the packet to send |
| tx_ready | output | 1 | Send may be accepted this cycle |
| tx_addr | output | AW | Start address of the outgoing payload |
| rx_valid | output | 1 | An incoming packet is held for local logic |
| rx_addr | output | AW | Start address of the incoming payload |
| rx_len | output | LW | Length of the incoming packet |
| rx_ack | input | 1 | Local logic has consumed the incoming packet |
| err | output | 1 | One-cycle pulse on a dropped host command |

## Verification
The bench timestamps every memory write, status write and output data byte by cycle, so that latency can be checked exactly. Header words must land on consecutive cycles. A dummy must follow its status write by one cycle, and the negotiated-version word must precede its status write by one cycle. `rx_valid` is sampled two cycles after the host command (still low) and three cycles after (high). `rx_valid` must fall one cycle after `rx_ack`. A byte stalled behind a slow host read must appear exactly two cycles after the host model releases Output Buffer Full. Dropped commands are checked by a count of new events, which must be zero, and by a count of `err` pulses.

// File: rtl/pktchan_ctrl.sv
module pktchan_ctrl #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int QDEPTH = 4,
  parameter logic [15:0] VER_MIN = 16'd1,
  parameter logic [15:0] VER_CUR = 16'd2,
  parameter logic [15:0] NEG_VER = 16'd2,
  parameter int TXA_OFF = 256,
  parameter int RXA_OFF = 512,
  parameter int AREA_BYTES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mb_ibf,
  input  logic [7:0]    mb_idr,
  output logic          mb_idr_rd,
  input  logic          mb_obf,
  output logic          mb_odr_wr,
  output logic [7:0]    mb_odr_data,
  output logic          mb_str_wr,
  output logic [7:0]    mb_str_data,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          tx_req,
  input  logic [LW-1:0] tx_len,
  output logic          tx_ready,
  output logic [AW-1:0] tx_addr,
  output logic          rx_valid,
  output logic [AW-1:0] rx_addr,
  output logic [LW-1:0] rx_len,
  input  logic          rx_ack,
  output logic          err
);
  localparam int QW = $clog2(QDEPTH);
  localparam int CW = QW + 1;
  localparam logic [7:0] C_INIT = 8'h00, C_TXB = 8'h01, C_RXC = 8'h02, C_DUMMY = 8'hFF;
  localparam logic [31:0] MAXLEN = 32'(AREA_BYTES - 4);

  typedef enum logic [2:0] {ST_HDR, ST_IDLE, ST_NEG, ST_RD0, ST_RD1} st_t;

  st_t st;
  logic [2:0] hdr_idx;
  logic bmc_act, ch_act, tx_busy;
  logic [7:0] q [QDEPTH];
  logic [QW-1:0] wp, rp;
  logic [CW-1:0] cnt, free;
  logic idle, cmd_take, rx_take, tx_take, hdr_last, init_act, enq, deq;
  logic [7:0] enq_byte;
  logic [AW-1:0] hdr_addr;
  logic [31:0] hdr_data;

  assign idle      = (st == ST_IDLE);
  assign free      = CW'(QDEPTH) - cnt;
  assign cmd_take  = idle && mb_ibf && (free >= CW'(2));
  assign rx_take   = idle && rx_valid && rx_ack && !mb_ibf && (free != '0);
  assign tx_ready  = idle && ch_act && !tx_busy && !mb_ibf && !(rx_valid && rx_ack) && (free != '0);
  assign tx_take   = tx_ready && tx_req;
  assign hdr_last  = (st == ST_HDR) && (hdr_idx == 3'd6);
  assign init_act  = cmd_take && (mb_idr == C_INIT) && ch_act;
  assign enq       = hdr_last || (st == ST_NEG) || init_act || rx_take || tx_take;
  assign enq_byte  = rx_take ? C_RXC : (tx_take ? C_TXB : C_DUMMY);
  assign deq       = (cnt != '0) && !mb_obf && !mb_odr_wr;
  assign mb_idr_rd = cmd_take;
  assign tx_addr   = AW'(TXA_OFF + 4);
  assign rx_addr   = AW'(RXA_OFF + 4);

  always_comb begin
    hdr_addr = '0;
    hdr_data = '0;
    case (hdr_idx)
      3'd0: begin hdr_addr = AW'(8'h00); hdr_data = 32'h4D435450; end
      3'd1: begin hdr_addr = AW'(8'h04); hdr_data = {VER_MIN, VER_CUR}; end
      3'd2: begin hdr_addr = AW'(8'h10); hdr_data = 32'(TXA_OFF); end
      3'd3: begin hdr_addr = AW'(8'h14); hdr_data = 32'(AREA_BYTES); end
      3'd4: begin hdr_addr = AW'(8'h18); hdr_data = 32'(RXA_OFF); end
      3'd5: begin hdr_addr = AW'(8'h1C); hdr_data = 32'(AREA_BYTES); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_HDR;
      hdr_idx <= '0;
      bmc_act <= 1'b0;
      ch_act <= 1'b0;
      tx_busy <= 1'b0;
      rx_valid <= 1'b0;
      rx_len <= '0;
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      mb_odr_wr <= 1'b0;
      mb_odr_data <= '0;
      mb_str_wr <= 1'b0;
      mb_str_data <= '0;
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      mem_addr <= '0;
      mem_wdata <= '0;
      err <= 1'b0;
      for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      mb_str_wr <= 1'b0;
      err <= 1'b0;
      mb_odr_wr <= deq;
      if (deq) begin
        mb_odr_data <= q[rp];
        rp <= rp + 1'b1;
      end
      if (enq) begin
        q[wp] <= enq_byte;
        wp <= wp + 1'b1;
      end
      cnt <= cnt + CW'(enq) - CW'(deq);
      case (st)
        ST_HDR: begin
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_last) begin
            bmc_act <= 1'b1;
            mb_str_wr <= 1'b1;
            mb_str_data <= 8'h80;
            st <= ST_IDLE;
          end else begin
            mem_we <= 1'b1;
            mem_addr <= hdr_addr;
            mem_wdata <= hdr_data;
          end
        end
        ST_IDLE: begin
          if (cmd_take) begin
            case (mb_idr)
              C_INIT: begin
                tx_busy <= 1'b0;
                rx_valid <= 1'b0;
                if (ch_act) begin
                  ch_act <= 1'b0;
                  mb_str_wr <= 1'b1;
                  mb_str_data <= {bmc_act, 7'b0};
                end
                mem_we <= 1'b1;
                mem_addr <= AW'(8'h0C);
                mem_wdata <= {NEG_VER, 16'h0};
                st <= ST_NEG;
              end
              C_TXB: begin
                if (ch_act) begin
                  mem_re <= 1'b1;
                  mem_addr <= AW'(RXA_OFF);
                  st <= ST_RD0;
                end else err <= 1'b1;
              end
              C_RXC: begin
                if (ch_act) tx_busy <= 1'b0;
                else err <= 1'b1;
              end
              default: err <= 1'b1;
            endcase
          end else if (rx_take) begin
            rx_valid <= 1'b0;
          end else if (tx_take) begin
            tx_busy <= 1'b1;
            mem_we <= 1'b1;
            mem_addr <= AW'(TXA_OFF);
            mem_wdata <= 32'(tx_len);
          end
        end
        ST_NEG: begin
          ch_act <= 1'b1;
          mb_str_wr <= 1'b1;
          mb_str_data <= {bmc_act, 1'b1, 6'b0};
          st <= ST_IDLE;
        end
        ST_RD0: st <= ST_RD1;
        ST_RD1: begin
          rx_len <= (mem_rdata > MAXLEN) ? LW'(MAXLEN) : mem_rdata[LW-1:0];
          rx_valid <= 1'b1;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ODR_OBF: assert property (@(posedge clk) disable iff (!rst_n) mb_odr_wr |-> !mb_obf) else $error("odr written while obf"); // R3
  AST_ODR_GAP: assert property (@(posedge clk) disable iff (!rst_n) mb_odr_wr |=> !mb_odr_wr) else $error("back to back odr"); // R3
  AST_STR_FMT: assert property (@(posedge clk) disable iff (!rst_n) mb_str_wr |-> (mb_str_data[7] && mb_str_data[5:0] == 6'b0)) else $error("status format"); // R2
  AST_CTRL_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (mem_we && ch_act) |-> (mem_addr == AW'(TXA_OFF))) else $error("write outside tx area"); // R10
  AST_TX_OWN: assert property (@(posedge clk) disable iff (!rst_n) (tx_ready && tx_req) |=> !tx_ready) else $error("tx ownership"); // R8
  AST_RX_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_valid) |-> ch_act) else $error("rx while inactive"); // R6
endmodule

// File: tb/pktchan_ctrl_test.sv
`timescale 1ns/1ps
module pktchan_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic mb_ibf = 1'b0, mb_obf = 1'b0, tx_req = 1'b0, rx_ack = 1'b0;
  logic [7:0] mb_idr = 8'h0;
  logic [31:0] mem_rdata = 32'h0;
  logic [15:0] tx_len = 16'h0;
  logic mb_idr_rd, mb_odr_wr, mb_str_wr, mem_we, mem_re, tx_ready, rx_valid, err;
  logic [7:0] mb_odr_data, mb_str_data;
  logic [15:0] mem_addr, tx_addr, rx_addr, rx_len;
  logic [31:0] mem_wdata;

  pktchan_ctrl uut (.*);

  int tests = 0, fails = 0, nev = 0, cyc = 0, err_cnt = 0, obf_viol = 0, lock_viol = 0;
  int host_delay = 1, hold = 0;
  int ev_k [256];
  logic [31:0] ev_a [256], ev_d [256];
  int ev_t [256];
  logic pend_obf = 1'b0, pend_clr = 1'b0, chk_lock = 1'b0;
  logic [31:0] rd_word = 32'h0;

  task automatic logev(int k, logic [31:0] a, logic [31:0] d);
    if (nev < 256) begin ev_k[nev] = k; ev_a[nev] = a; ev_d[nev] = d; ev_t[nev] = cyc; nev++; end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_we) begin
        logev(1, 32'(mem_addr), mem_wdata);
        if (chk_lock && mem_addr != 16'h0100) lock_viol++;
      end
      if (mb_str_wr) logev(2, 0, 32'(mb_str_data));
      if (mb_odr_wr) begin
        logev(3, 0, 32'(mb_odr_data));
        if (mb_obf) obf_viol++;
        pend_obf = 1'b1;
      end
      if (mb_idr_rd) pend_clr = 1'b1;
      if (mem_re) mem_rdata = rd_word;
      if (err) err_cnt++;
    end
  end

  always @(posedge clk) begin
    #1;
    if (mb_obf) begin
      hold++;
      if (hold >= host_delay) begin mb_obf = 1'b0; hold = 0; end
    end
    if (pend_obf) begin mb_obf = 1'b1; pend_obf = 1'b0; end
    if (pend_clr) begin mb_ibf = 1'b0; pend_clr = 1'b0; end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic check_ev(int i, int k, logic [31:0] a, logic [31:0] d, string tag);
    tests++;
    if (i >= nev || ev_k[i] != k || ev_a[i] != a || ev_d[i] != d) begin
      fails++;
      if (i >= nev) $display("FAIL %s actual=missing event %0d expected kind=%0d addr=%h data=%h", tag, i, k, a, d);
      else $display("FAIL %s actual kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                    tag, ev_k[i], ev_a[i], ev_d[i], k, a, d);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_cmd(logic [7:0] b);
    @(negedge clk);
    while (mb_ibf) @(negedge clk);
    mb_ibf = 1'b1;
    mb_idr = b;
  endtask

  task automatic do_tx(logic [15:0] len);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_len = len;
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    int base, e0;
    wait_n(3);
    check({mb_str_wr, mb_odr_wr, mem_we, mem_re, tx_ready, rx_valid, err} == 7'b0, "R1 reset outputs",
          32'({mb_str_wr, mb_odr_wr, mem_we, mem_re, tx_ready, rx_valid, err}), 0);
    rst_n = 1'b1;
    wait_n(20);
    check_ev(0, 1, 32'h00, 32'h4D435450, "R1 magic");
    check_ev(1, 1, 32'h04, 32'h00010002, "R1 versions");
    check_ev(2, 1, 32'h10, 32'h100, "R1 host rx offset");
    check_ev(3, 1, 32'h14, 32'h100, "R1 host rx size");
    check_ev(4, 1, 32'h18, 32'h200, "R1 host tx offset");
    check_ev(5, 1, 32'h1C, 32'h100, "R1 host tx size");
    for (int i = 0; i < 5; i++) check(ev_t[i+1] == ev_t[i] + 1, "R1 consecutive header", ev_t[i+1], ev_t[i] + 1);
    check_ev(6, 2, 0, 32'h80, "R1 controller up status");
    check_ev(7, 3, 0, 32'hFF, "R2 dummy after status");
    check(ev_t[7] == ev_t[6] + 1, "R2 dummy timing", ev_t[7], ev_t[6] + 1);
    check(tx_ready == 1'b0, "R8 tx_ready low before channel up", 32'(tx_ready), 0);

    base = nev; e0 = err_cnt;
    host_cmd(8'h01); wait_n(6);
    host_cmd(8'h02); wait_n(6);
    host_cmd(8'h55); wait_n(6);
    check(err_cnt == e0 + 3, "R9 err pulses", err_cnt - e0, 3);
    check(nev == base, "R9 no traffic on dropped commands", nev - base, 0);
    check(rx_valid == 1'b0, "R9 no rx handoff", 32'(rx_valid), 0);

    base = nev;
    host_cmd(8'h00); wait_n(10);
    check_ev(base, 1, 32'h0C, 32'h00020000, "R4 negotiated version");
    check_ev(base + 1, 2, 0, 32'hC0, "R4 channel up status");
    check_ev(base + 2, 3, 0, 32'hFF, "R4 dummy");
    check(ev_t[base + 1] == ev_t[base] + 1, "R4 status after version", ev_t[base + 1], ev_t[base] + 1);
    chk_lock = 1'b1;
    check(tx_ready == 1'b1, "R8 tx_ready after channel up", 32'(tx_ready), 1);
    check(tx_addr == 16'h0104, "R8 tx_addr", 32'(tx_addr), 32'h104);

    for (int i = 0; i < 6; i++) begin
      logic [15:0] len;
      len = 16'(i * 50 + 1);
      base = nev;
      do_tx(len); wait_n(4);
      check_ev(base, 1, 32'h100, 32'(len), "R8 length word");
      check_ev(base + 1, 3, 0, 32'h01, "R8 transmit begin byte");
      check(tx_ready == 1'b0, "R8 busy until receive complete", 32'(tx_ready), 0);
      if (i == 0) begin
        tx_req = 1'b1; wait_n(3); tx_req = 1'b0; wait_n(2);
        check(nev == base + 2, "R8 request ignored while busy", nev - base, 2);
      end
      host_cmd(8'h02); wait_n(3);
      check(tx_ready == 1'b1, "R8 ownership returned", 32'(tx_ready), 1);
    end

    for (int i = 0; i < 8; i++) begin
      logic [31:0] lw, expl;
      case (i)
        0: lw = 0; 1: lw = 1; 2: lw = 64; 3: lw = 251;
        4: lw = 252; 5: lw = 253; 6: lw = 32'hFFFF; default: lw = 32'h10000;
      endcase
      expl = (lw > 252) ? 252 : lw;
      rd_word = lw;
      base = nev;
      host_cmd(8'h01);
      wait_n(2);
      check(rx_valid == 1'b0, "R6 rx_valid not early", 32'(rx_valid), 0);
      wait_n(1);
      check(rx_valid == 1'b1, "R6 rx_valid at third cycle", 32'(rx_valid), 1);
      check(32'(rx_len) == expl, "R11 rx length", 32'(rx_len), expl);
      check(rx_addr == 16'h0204, "R6 rx_addr", 32'(rx_addr), 32'h204);
      rx_ack = 1'b1; wait_n(1); rx_ack = 1'b0;
      check(rx_valid == 1'b0, "R7 rx_valid falls", 32'(rx_valid), 0);
      wait_n(3);
      check_ev(base, 3, 0, 32'h02, "R7 receive complete byte");
    end

    host_delay = 8;
    host_cmd(8'h01); wait_n(4);
    base = nev;
    rx_ack = 1'b1; wait_n(1); rx_ack = 1'b0;
    do_tx(16'd9);
    wait_n(20);
    check_ev(base, 3, 0, 32'h02, "R3 first queued byte");
    check_ev(base + 1, 1, 32'h100, 32'd9, "R8 length word under stall");
    check_ev(base + 2, 3, 0, 32'h01, "R3 second queued byte");
    check(ev_t[base + 2] - ev_t[base] == host_delay + 2, "R3 stall release timing",
          ev_t[base + 2] - ev_t[base], host_delay + 2);
    check(obf_viol == 0, "R3 no write under obf", obf_viol, 0);
    host_delay = 1;
    wait_n(3);

    host_cmd(8'h01); wait_n(4);
    check(rx_valid == 1'b1 && tx_ready == 1'b0, "R5 setup pending state", 32'({rx_valid, tx_ready}), 2);
    base = nev; chk_lock = 1'b0;
    host_cmd(8'h00); wait_n(15);
    check_ev(base, 1, 32'h0C, 32'h00020000, "R5 version rewritten");
    check_ev(base + 1, 2, 0, 32'h80, "R5 channel down status");
    check_ev(base + 2, 2, 0, 32'hC0, "R5 channel up again");
    check_ev(base + 3, 3, 0, 32'hFF, "R5 first dummy");
    check_ev(base + 4, 3, 0, 32'hFF, "R5 second dummy");
    check(rx_valid == 1'b0, "R5 rx handoff dropped", 32'(rx_valid), 0);
    check(tx_ready == 1'b1, "R5 tx area freed", 32'(tx_ready), 1);
    chk_lock = 1'b1;
    do_tx(16'd3); wait_n(4);
    host_cmd(8'h02); wait_n(3);
    check(lock_viol == 0, "R10 writes only to tx area", lock_viol, 0);
    finish_up();
  end
endmodule